// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock

This block sits between the switching-pattern generator of a motor or inverter controller and the gate-driver stages of a bridge. It has one leg per phase. Each leg takes an already-filtered high-side command and low-side command and turns them into the two enables that the output stages actually see.

Each leg enforces two rules.

- It never lets both switches of the leg conduct. When both commands are asserted together, both enables go low.
- It holds both enables low for at least a fixed number of clock cycles between one switch turning off and the other turning on. The rule applies in both directions.

If the controller already leaves a longer gap, the gap passes through untouched. Dead time is only added when the commanded gap is too short.

All timing is counted in cycles of `clk`. The `DEAD_CYC` parameter sets the minimum off interval. For example, 29 cycles at 100 MHz gives roughly 290 ns. Every enable is registered, so each enable follows its command with a latency of exactly one cycle, except where the interlock delays a turn-on. The three legs of a three-phase bridge are fully independent copies.

Top module: `bridge_interlock`

## Requirements
- R1: Outputs are non-inverting. A high command, with the leg's other command low and the other enable off for at least `DEAD_CYC` cycles, drives the matching enable high on the next clock edge.
- R2: When a leg's high-side and low-side commands are both 1, both of that leg's enables are 0 after the next edge. Command pairs (high, low) map to enables as follows: 00 gives 00, 01 gives 01, 10 gives 10, and 11 gives 00.
- R3: The high-side enable and the low-side enable of the same leg are never 1 in the same cycle.
- R4: When one enable turns off and the opposite command arrives fewer than `DEAD_CYC` cycles after the falling command, the opposite enable rises only after exactly `DEAD_CYC` cycles with both enables low.
- R5: When the commanded gap is `DEAD_CYC` cycles or longer, the opposite enable rises one cycle after its command, so the both-off interval equals the commanded gap.
- R6: The inserted interval is the same for low-off-to-high-on as for high-off-to-low-on.
- R7: If a command drops, or the other command rises, while its turn-on is still waiting out the dead time, the pending turn-on is cancelled and the enable stays low.
- R8: After synchronous reset (`rst` = 1, active high), all enables are 0 and the dead-time timers are expired, so the first command after reset turns on one cycle later.
- R9: The legs are independent. Commands on one leg never change the enables of another leg.
- R10: Turn-off is never delayed. A command that goes low clears its enable on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | PHASES | Filtered high-side command, one bit per leg |
| lo_cmd | input | PHASES | Filtered low-side command, one bit per leg |
| hi_en | output | PHASES | Gated high-side drive enable, one bit per leg |
| lo_en | output | PHASES | Gated low-side drive enable, one bit per leg |

## Verification
The hardest situation to reach from the ports is the boundary between an inserted dead time and a commanded gap that passes through. Here a commanded gap of `DEAD_CYC`-1, `DEAD_CYC` or `DEAD_CYC`+1 cycles must produce exactly `max(gap, DEAD_CYC)` both-off cycles, in each direction.

The stimulus reaches it with a small `DEAD_CYC` and a sweep of every gap from zero to two past the limit. The sweep runs on one leg, with a mirrored copy on a second leg and a held 11 command on the third. Each both-off interval is measured at the enables and compared with the arithmetic expectation.

A cancelled turn-on is reached by withdrawing the command partway through the wait. A long pseudo-random run then drives all legs against a timestamp model.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  // Next value of a saturating "opposite side has been quiet" counter.
  function automatic int unsigned quiet_next(int unsigned cur, logic opp_on,
                                             int unsigned lim);
    if (opp_on) return 0;
    else if (cur >= lim) return lim;
    else return cur + 1;
  endfunction

  // Turn-on is allowed on this edge when the opposite enable is already off
  // and it will have been off for lim cycles once this edge has passed.
  function automatic logic quiet_done(int unsigned cur, logic opp_on,
                                      int unsigned lim);
    return !opp_on && ((cur + 1) >= lim);
  endfunction

  // Gate one side: own command present, other command absent, timer done.
  function automatic logic gate_on(logic own_cmd, logic other_cmd, logic done);
    return own_cmd && !other_cmd && done;
  endfunction

endpackage

// File: rtl/ilk_quiet_timer.sv
module ilk_quiet_timer #(
  parameter int DEAD = 29
) (
  input  logic clk,
  input  logic rst,
  input  logic opp_on,
  output logic done
);
  localparam int CNT_W = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
  localparam int unsigned LIM = DEAD;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(ilk_pkg::quiet_next(32'(cnt_q), opp_on, LIM));
    done  = ilk_pkg::quiet_done(32'(cnt_q), opp_on, LIM);
  end

  // Reset to the saturated value: the timer starts expired.
  always_ff @(posedge clk) begin
    if (rst) cnt_q <= CNT_W'(LIM);
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ilk_leg.sv
module ilk_leg #(
  parameter int DEAD = 29
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_cmd,
  input  logic lo_cmd,
  output logic hi_en,
  output logic lo_en
);
  localparam int CNT_W = (DEAD < 1) ? 1 : $clog2(DEAD + 1);

  logic hi_q, lo_q;
  logic hi_ready, lo_ready;   // dead-time timers expired
  logic hi_go, lo_go;         // gated next-state of each enable

  // High side waits for the low enable to be quiet, and vice versa.
  ilk_quiet_timer #(.DEAD(DEAD)) u_hi_timer (
    .clk(clk), .rst(rst), .opp_on(lo_q), .done(hi_ready)
  );
  ilk_quiet_timer #(.DEAD(DEAD)) u_lo_timer (
    .clk(clk), .rst(rst), .opp_on(hi_q), .done(lo_ready)
  );

  always_comb begin
    hi_go = ilk_pkg::gate_on(hi_cmd, lo_cmd, hi_ready);
    lo_go = ilk_pkg::gate_on(lo_cmd, hi_cmd, lo_ready);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_go;
      lo_q <= lo_go;
    end
  end

  assign hi_en = hi_q;
  assign lo_en = lo_q;

  // ---------------- checker state and assertions ----------------
  // Independent quiet-run counters, saturating at DEAD, used only by checks.
  logic [CNT_W-1:0] lo_quiet, hi_quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_quiet <= CNT_W'(DEAD);
      hi_quiet <= CNT_W'(DEAD);
    end else begin
      if (lo_q) lo_quiet <= '0;
      else if (lo_quiet != CNT_W'(DEAD)) lo_quiet <= lo_quiet + 1'b1;
      if (hi_q) hi_quiet <= '0;
      else if (hi_quiet != CNT_W'(DEAD)) hi_quiet <= hi_quiet + 1'b1;
    end
  end

  a_r3_never_both: assert property (@(posedge clk) disable iff (rst)
    !(hi_q && lo_q));

  a_r2_both_cmd_off: assert property (@(posedge clk) disable iff (rst)
    (hi_cmd && lo_cmd) |=> (!hi_q && !lo_q));

  a_r10_hi_off_prompt: assert property (@(posedge clk) disable iff (rst)
    !hi_cmd |=> !hi_q);

  a_r10_lo_off_prompt: assert property (@(posedge clk) disable iff (rst)
    !lo_cmd |=> !lo_q);

  a_r4_hi_dead_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> (lo_quiet >= CNT_W'(DEAD)));

  a_r6_lo_dead_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> (hi_quiet >= CNT_W'(DEAD)));

  a_r7_hi_rise_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> $past(hi_cmd && !lo_cmd));

  a_r7_lo_rise_needs_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_q) |-> $past(lo_cmd && !hi_cmd));

endmodule

// File: rtl/bridge_interlock.sv
module bridge_interlock #(
  parameter int PHASES   = 3,
  parameter int DEAD_CYC = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] hi_cmd,
  input  logic [PHASES-1:0] lo_cmd,
  output logic [PHASES-1:0] hi_en,
  output logic [PHASES-1:0] lo_en
);

  for (genvar p = 0; p < PHASES; p++) begin : g_leg
    ilk_leg #(.DEAD(DEAD_CYC)) u_leg (
      .clk   (clk),
      .rst   (rst),
      .hi_cmd(hi_cmd[p]),
      .lo_cmd(lo_cmd[p]),
      .hi_en (hi_en[p]),
      .lo_en (lo_en[p])
    );
  end

endmodule

// File: tb/bridge_interlock_test.sv
module bridge_interlock_test;
  localparam int D = 4;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] hi_cmd = '0, lo_cmd = '0;
  logic [NP-1:0] hi_en, lo_en;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state: expected enables and edge index at which each enable fell
  logic [NP-1:0] eh = '0, el = '0;
  int hi_fall[NP], lo_fall[NP];
  int t = 0;

  // gap measurement on leg 0
  int run0 = 0, gap_h = -1, gap_l = -1;
  logic ph0 = 0, pl0 = 0;

  always #10 clk = ~clk;   // 50 MHz

  bridge_interlock #(.PHASES(NP), .DEAD_CYC(D)) uut (
    .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .hi_en(hi_en), .lo_en(lo_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", tag, act, exp, t);
    end
  endtask

  // One cycle: check the outputs, then apply the next commands and advance the model.
  task automatic cyc(input logic [NP-1:0] hv, input logic [NP-1:0] lv, input string tag);
    logic [NP-1:0] nh, nl;
    @(negedge clk);
    chk({hi_en, lo_en} === {eh, el}, tag, int'({hi_en, lo_en}), int'({eh, el}));
    chk((hi_en & lo_en) == '0, "R3 never both on", int'(hi_en & lo_en), 0);
    if (hi_en[0] && !ph0) gap_h = run0;
    if (lo_en[0] && !pl0) gap_l = run0;
    if (!hi_en[0] && !lo_en[0]) run0++; else run0 = 0;
    ph0 = hi_en[0]; pl0 = lo_en[0];
    hi_cmd = hv; lo_cmd = lv;
    for (int p = 0; p < NP; p++) begin
      nh[p] = hv[p] && !lv[p] && !el[p] && ((t - lo_fall[p]) >= D);
      nl[p] = lv[p] && !hv[p] && !eh[p] && ((t - hi_fall[p]) >= D);
      if (eh[p] && !nh[p]) hi_fall[p] = t;
      if (el[p] && !nl[p]) lo_fall[p] = t;
    end
    eh = nh; el = nl;
    t++;
  endtask

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic sweep(input int g);
    string tg;
    // leg0: low on -> gap -> high on -> gap -> low on; leg1 mirrored; leg2 held 11
    repeat (D + 3) cyc({1'b1, 1'b0, 1'b0}, {1'b1, 1'b0, 1'b1}, "R6 low on");
    repeat (g)     cyc({1'b1, 1'b0, 1'b0}, {1'b1, 1'b0, 1'b0}, "R10 both released");
    gap_h = -1;
    tg = (g < D) ? "R4 short gap hi" : "R5 long gap hi";
    repeat (D + 3) cyc({1'b1, 1'b0, 1'b1}, {1'b1, 1'b1, 1'b0}, tg);
    chk(gap_h == mx(g, D), (g < D) ? "R4 both-off cycles before hi" :
                                      "R5 both-off cycles before hi", gap_h, mx(g, D));
    repeat (g)     cyc({1'b1, 1'b0, 1'b0}, {1'b1, 1'b0, 1'b0}, "R10 both released");
    gap_l = -1;
    repeat (D + 3) cyc({1'b1, 1'b1, 1'b0}, {1'b1, 1'b0, 1'b1}, "R6 low after gap");
    chk(gap_l == mx(g, D), "R6 both-off cycles before lo", gap_l, mx(g, D));
    chk(hi_en[2] == 1'b0 && lo_en[2] == 1'b0, "R2 leg2 held 11",
        int'({hi_en[2], lo_en[2]}), 0);
  endtask

  initial begin
    logic [15:0] lf;
    for (int p = 0; p < NP; p++) begin hi_fall[p] = -1000; lo_fall[p] = -1000; end
    repeat (3) @(negedge clk);
    chk(hi_en == '0 && lo_en == '0, "R8 reset outputs", int'({hi_en, lo_en}), 0);
    rst = 1'b0;
    // R8: first turn-on right after reset is not delayed
    cyc(3'b001, 3'b010, "R8 first command");
    cyc(3'b001, 3'b010, "R1 in-phase");
    chk(hi_en == 3'b001 && lo_en == 3'b010, "R8 first turn-on one cycle",
        int'({hi_en, lo_en}), int'({3'b001, 3'b010}));
    cyc(3'b000, 3'b000, "R10 turn-off");
    cyc(3'b000, 3'b000, "R10 turn-off");
    chk(hi_en == '0 && lo_en == '0, "R10 prompt turn-off", int'({hi_en, lo_en}), 0);
    // R2 truth table on every leg
    repeat (3) cyc(3'b111, 3'b111, "R2 both commands");
    chk(hi_en == '0 && lo_en == '0, "R2 11 gives 00", int'({hi_en, lo_en}), 0);
    // gap sweep
    for (int g = 0; g <= D + 2; g++) sweep(g);
    // R7: cancel a pending turn-on
    repeat (D + 2) cyc(3'b000, 3'b001, "R7 low on");
    repeat (D - 2) cyc(3'b001, 3'b000, "R7 pending hi");
    repeat (D + 2) cyc(3'b000, 3'b000, "R7 cancelled");
    chk(hi_en[0] == 1'b0, "R7 cancelled turn-on", int'(hi_en[0]), 0);
    // R9: pseudo-random run on all legs
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[2:0] & lf[8:6], lf[5:3] & lf[11:9], "R9 random legs");
    end
    cyc(3'b000, 3'b000, "R9 final");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(64'd20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule